// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block holds the digital timing and counting for an integrating (dual-slope) analog-to-digital converter. A trigger pulse starts a conversion. From then on, every step is paced by a single-cycle tick enable that nominally arrives once per microsecond.

Each conversion runs through these steps:

1. **Integration.** The block asserts `integ` for a fixed number of ticks.
2. **Run-down.** It switches to `rundown`. During the first part of run-down, only the low section of the result counter advances. That section wraps to zero, which discards a fixed offset-compensation count. The whole counter then advances while the synchronized comparator input reports that the integrator is still away from zero.
3. **Over-range.** If the comparator reports zero already inside the offset window, the conversion is clamped to negative full scale. If the counter reaches all ones, it saturates and the conversion is clamped to positive full scale.
4. **Hand-off.** At a fixed tick count after the trigger, the block raises a one-clock latch strobe that copies the two's-complement result into the output register. On the next clock it raises a one-clock end-of-conversion pulse that clears all state.

The result leaves the block as a plain registered value. There is no valid/ready pair. `hold_n` is the only back-pressure: when it is low during the latch clock, no transfer takes place and the previous result stays on `result`. The new value is lost, not retried. All other pins are plain control levels or pulses.

Top module: `dsadc_ctrl`

## Requirements
- R1: While reset is held, and right after it, `integ`, `rundown`, `latch_stb` and `eoc` are low and `result` is zero.
- R2: A `start` sampled high while the block is idle begins a conversion on that clock edge. `integ` is then high for exactly INT_TICKS ticks (2048 by default), and `rundown` rises on the edge of the INT_TICKS-th tick.
- R3: For the first OFF_TICKS ticks of run-down (256 by default), only the low log2(OFF_TICKS) bits of the counter advance. Those bits wrap to zero, so these ticks never reach the result.
- R4: `ramp_active` passes through two flip-flops. A level driven between clock edges is therefore acted on at the third following edge. After the offset window, the counter advances on each tick for which the synchronized level is high, and counting stops at the first tick on which it is low.
- R5: The result is the 11-bit count with its MSB inverted, read as two's complement. The output therefore equals count minus 1024, with bit 10 as the sign bit.
- R6: If the synchronized `ramp_active` is low on any tick inside the offset window, the counter is held at zero for the rest of the conversion, even if `ramp_active` rises again. The result is then 10000000000 (-1024).
- R7: If the count reaches 2047, it stays there and the result is 01111111111 (+1023).
- R8: `latch_stb` is high for one clock. It follows the edge of the LATCH_AT-th tick after the start edge (4750 by default). On the next edge, `result` takes the new value.
- R9: `eoc` is high for the single clock after the latch clock. The block then returns to idle with its counter cleared, ready for a new `start`.
- R10: If `hold_n` is low during the latch clock, `latch_stb` stays low and `result` keeps its previous value. `eoc` still occurs on schedule.
- R11: A `start` pulse during a conversion is ignored and does not change the timing of that conversion's strobe or end pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-clock count enable (1 µs pace) |
| start | input | 1 | Conversion trigger, accepted only while idle |
| ramp_active | input | 1 | Asynchronous comparator level, high while the integrator is away from zero |
| hold_n | input | 1 | Low when the previous result is only half read; blocks the transfer |
| integ | output | 1 | Integration phase control |
| rundown | output | 1 | Run-down phase control (offset window and counting) |
| result | output | 11 | Latched two's-complement conversion result |
| latch_stb | output | 1 | One-clock strobe marking a result transfer |
| eoc | output | 1 | One-clock end-of-conversion pulse |

## Verification
The assertions assume the following about the inputs:
- `tick` is a single-clock enable.
- `hold_n` does not change during the latch clock.
- `start` may arrive at any time.

The stimulus keeps `tick` high on every clock, so each clock is one tick and expected counts follow directly from the two-flop synchronizer latency. It changes `ramp_active` and `start` only at falling clock edges, relative to the observed rise of `rundown`. It holds `hold_n` constant for a whole conversion.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_INTEG,
    PH_OFFS,
    PH_RUN,
    PH_WAIT,
    PH_LATCH,
    PH_EOC
  } phase_t;
endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/dsadc_count.sv
module dsadc_count #(
  parameter int W     = 11,
  parameter int LOW_W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic         upper_en,
  output logic [W-1:0] cnt,
  output logic         low_max,
  output logic         full
);
  localparam int HI_W = W - LOW_W;

  logic [LOW_W-1:0] lo;
  logic [HI_W-1:0]  hi;

  assign cnt     = {hi, lo};
  assign low_max = &lo;
  assign full    = &cnt;

  // low section always advances on inc; carry into the upper section only when enabled
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      lo <= '0;
      hi <= '0;
    end else if (inc && !(upper_en && full)) begin
      lo <= lo + 1'b1;
      if (upper_en && (&lo)) hi <= hi + 1'b1;
    end
  end

  assert_upper_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!upper_en && !clr) |=> $stable(hi));

  assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr) |=> full);

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int TIME_W    = 13,
  parameter int INT_TICKS = 2048,
  parameter int LATCH_AT  = 4750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  input  logic ramp_s,
  input  logic low_max,
  output logic integ,
  output logic rundown,
  output logic latch_ph,
  output logic eoc,
  output logic cnt_clr,
  output logic cnt_inc,
  output logic cnt_upper_en
);
  localparam logic [TIME_W-1:0] T_INT_END = TIME_W'(INT_TICKS - 1);
  localparam logic [TIME_W-1:0] T_LATCH   = TIME_W'(LATCH_AT - 1);

  phase_t            st;
  logic [TIME_W-1:0] tcnt;
  logic              neg_q;
  logic              busy;

  assign busy = (st == PH_INTEG) || (st == PH_OFFS) || (st == PH_RUN) || (st == PH_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= PH_IDLE;
      tcnt  <= '0;
      neg_q <= 1'b0;
    end else begin
      if (st == PH_IDLE || st == PH_EOC) tcnt <= '0;
      else if (tick)                     tcnt <= tcnt + 1'b1;

      if (busy && tick && tcnt == T_LATCH) begin
        st <= PH_LATCH;
      end else begin
        case (st)
          PH_IDLE:  if (start) st <= PH_INTEG;
          PH_INTEG: if (tick && tcnt == T_INT_END) st <= PH_OFFS;
          PH_OFFS: begin
            if (tick) begin
              if (!ramp_s) begin
                st    <= PH_WAIT;
                neg_q <= 1'b1;
              end else if (low_max) begin
                st <= PH_RUN;
              end
            end
          end
          PH_RUN:   if (tick && !ramp_s) st <= PH_WAIT;
          PH_LATCH: st <= PH_EOC;
          PH_EOC: begin
            st    <= PH_IDLE;
            neg_q <= 1'b0;
          end
          default:  st <= st;
        endcase
      end
    end
  end

  assign integ        = (st == PH_INTEG);
  assign rundown      = (st == PH_OFFS) || (st == PH_RUN);
  assign latch_ph     = (st == PH_LATCH);
  assign eoc          = (st == PH_EOC);
  assign cnt_inc      = tick && ramp_s && rundown;
  assign cnt_upper_en = (st == PH_RUN);
  assign cnt_clr      = eoc || neg_q;

  assert_phase_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({integ, rundown, latch_ph, eoc}));

  assert_eoc_after_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    latch_ph |=> eoc);

  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (integ && !(tick && tcnt == T_INT_END)) |=> integ);
endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl #(
  parameter int CNT_W     = 11,
  parameter int OFF_TICKS = 256,
  parameter int INT_TICKS = 2048,
  parameter int LATCH_AT  = 4750,
  parameter int SYNC_FF   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             ramp_active,
  input  logic             hold_n,
  output logic             integ,
  output logic             rundown,
  output logic [CNT_W-1:0] result,
  output logic             latch_stb,
  output logic             eoc
);
  localparam int LOW_W  = $clog2(OFF_TICKS);
  localparam int TIME_W = $clog2(LATCH_AT + 1);

  logic             ramp_s;
  logic             low_max, full;
  logic             cnt_clr, cnt_inc, cnt_upper_en;
  logic             latch_ph;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] res_q;

  dsadc_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ramp_active), .q(ramp_s)
  );

  dsadc_seq #(.TIME_W(TIME_W), .INT_TICKS(INT_TICKS), .LATCH_AT(LATCH_AT)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .ramp_s(ramp_s),
    .low_max(low_max), .integ(integ), .rundown(rundown), .latch_ph(latch_ph),
    .eoc(eoc), .cnt_clr(cnt_clr), .cnt_inc(cnt_inc), .cnt_upper_en(cnt_upper_en)
  );

  dsadc_count #(.W(CNT_W), .LOW_W(LOW_W)) u_count (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
    .upper_en(cnt_upper_en), .cnt(cnt), .low_max(low_max), .full(full)
  );

  assign latch_stb = latch_ph && hold_n;

  // inverted MSB turns the offset-binary count into two's complement
  always_ff @(posedge clk) begin
    if (!rst_n)         res_q <= '0;
    else if (latch_stb) res_q <= {~cnt[CNT_W-1], cnt[CNT_W-2:0]};
  end

  assign result = res_q;

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_stb |=> $stable(res_q));

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |=> !latch_stb);
endmodule

// File: tb/sim_dsadc_ctrl.sv
module sim_dsadc_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NEVER      = 99999;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        start = 1'b0;
  logic        ramp_active = 1'b1;
  logic        hold_n = 1'b1;
  logic        integ, rundown, latch_stb, eoc;
  logic [10:0] result;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsadc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
    .ramp_active(ramp_active), .hold_n(hold_n), .integ(integ),
    .rundown(rundown), .result(result), .latch_stb(latch_stb), .eoc(eoc)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_res(input int j);
    int c;
    if (j <= 254) return -1024;
    c = j - 254;
    if (c > 2047) c = 2047;
    return c - 1024;
  endfunction

  // one conversion; ramp drop/raise indices count clocks after rundown is first seen
  task automatic run_conv(input int drop_j, input int raise_j, input int retrig_n,
                          input bit hold, output int r_res, output int integ_len,
                          output int stb_n, output int eoc_n, output int stb_cnt);
    int n;
    bit done;
    n = 0; done = 0; integ_len = 0; stb_n = -1; eoc_n = -1; stb_cnt = 0;
    ramp_active = 1'b1;
    hold_n = hold;
    @(negedge clk);
    start = 1'b1;
    while (!done && n < 6000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == 1) start = 1'b0;
      if (n == retrig_n) start = 1'b1;
      if (n == retrig_n + 1) start = 1'b0;
      if (integ) integ_len++;
      if (latch_stb) begin
        stb_cnt++;
        if (stb_n < 0) stb_n = n;
      end
      if (eoc) begin
        eoc_n = n;
        done = 1;
      end
      if (n == 2049 + drop_j)  ramp_active = 1'b0;
      if (n == 2049 + raise_j) ramp_active = 1'b1;
    end
    chk(done, "R9 conversion ended", n, 4752);
    r_res = $signed(result);
    @(posedge clk);
    @(negedge clk);
    chk(!eoc && !integ && !rundown && !latch_stb, "R9 idle after eoc", eoc, 0);
    ramp_active = 1'b1;
    hold_n = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!integ && !rundown && !latch_stb && !eoc, "R1 controls low in reset", integ, 0);
    chk(result == 11'd0, "R1 result zero in reset", result, 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(!integ && !rundown && !eoc && result == 11'd0, "R1 idle after reset", result, 0);
  endtask

  task automatic t_normal();
    int r, il, sn, en, sc;
    run_conv(1254, NEVER, -10, 1'b1, r, il, sn, en, sc);
    chk(il == 2048, "R2 integ length", il, 2048);
    chk(sn == 4751, "R8 strobe position", sn, 4751);
    chk(sc == 1, "R8 single strobe", sc, 1);
    chk(en == 4752, "R9 eoc follows strobe", en, 4752);
    chk(r == exp_res(1254), "R4 count 1000", r, exp_res(1254));
  endtask

  task automatic t_codes();
    int r, il, sn, en, sc;
    run_conv(1278, NEVER, -10, 1'b1, r, il, sn, en, sc);
    chk(r == 0, "R5 mid-scale zero", r, 0);
    run_conv(255, NEVER, -10, 1'b1, r, il, sn, en, sc);
    chk(r == -1023, "R3 offset discarded, one count", r, -1023);
    run_conv(254, NEVER, -10, 1'b1, r, il, sn, en, sc);
    chk(r == -1024, "R4 zero count at run start", r, -1024);
  endtask

  task automatic t_neg();
    int r, il, sn, en, sc;
    run_conv(100, 400, -10, 1'b1, r, il, sn, en, sc);
    chk(r == -1024, "R6 negative over-range clamp", r, -1024);
    chk(en == 4752, "R6 eoc timing kept", en, 4752);
  endtask

  task automatic t_pos();
    int r, il, sn, en, sc;
    run_conv(NEVER, NEVER, -10, 1'b1, r, il, sn, en, sc);
    chk(r == 1023, "R7 positive over-range clamp", r, 1023);
    run_conv(2300, NEVER, -10, 1'b1, r, il, sn, en, sc);
    chk(r == 1022, "R7 one below full scale", r, 1022);
  endtask

  task automatic t_hold();
    int r, il, sn, en, sc;
    run_conv(1500, NEVER, -10, 1'b0, r, il, sn, en, sc);
    chk(sc == 0, "R10 strobe suppressed", sc, 0);
    chk(r == 1022, "R10 result kept", r, 1022);
    chk(en == 4752, "R10 eoc still issued", en, 4752);
    run_conv(1500, NEVER, -10, 1'b1, r, il, sn, en, sc);
    chk(r == exp_res(1500), "R10 transfer resumes", r, exp_res(1500));
  endtask

  task automatic t_retrig();
    int r, il, sn, en, sc;
    run_conv(1354, NEVER, 1000, 1'b1, r, il, sn, en, sc);
    chk(il == 2048, "R11 integ length unchanged", il, 2048);
    chk(sn == 4751, "R11 strobe position unchanged", sn, 4751);
    chk(r == exp_res(1354), "R11 result unaffected", r, exp_res(1354));
    run_conv(2054, NEVER, 3000, 1'b1, r, il, sn, en, sc);
    chk(en == 4752, "R11 eoc unchanged", en, 4752);
    chk(r == exp_res(2054), "R11 second result", r, exp_res(2054));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_normal();
    t_codes();
    t_neg();
    t_pos();
    t_hold();
    t_retrig();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule